// File: doc/BRIEF.md
# Serial-Capable Port Pin Multiplexer

This block is a six-pin slice of a general-purpose port. The pins can also carry the signals of two serial channels. For each channel, one pin carries transmit data, one carries receive data, and one is shared by the clear-to-send input and the serial clock. Software sets the pins through three per-bit registers, one for the output latch, one for direction and one for pin function, plus a one-bit receive-source select. All four are written over a simple internal bus with write strobes and are read back through a combinational read port.

When a pin feeds a serial channel input, the latch bit of that pin no longer drives anything visible. Instead it sets the polarity of the signal handed to the channel. A latch value of 0 inverts the signal, and a latch value of 1 passes it unchanged, so the reset value of all ones leaves every path uninverted. The receive data of channel 0 can be taken from its own pin or from an alternate input that belongs to another port. The pad is modelled as separate input, output and output-enable vectors. There is no data stream at the edge of this block, so every pin is a plain level with no handshake.

Pin numbering: channel k owns pins 3k (transmit), 3k+1 (receive) and 3k+2 (clock / clear-to-send).

Top module: `sio_pin_mux`

## Requirements
- R1: After reset, the latch reads all ones, and the direction register, the function register, the receive-source select and pad_oe all read zero.
- R2: A write with wr_latch high loads wr_data into the latch at the next rising clock edge. Without the strobe the latch holds its value.
- R3: Direction is set per bit by wr_dir, and pad_oe equals the direction register bit for bit.
- R4: With rd_sel=0, rd_data returns pad_in for bits whose direction is 0 and the latch for bits whose direction is 1.
- R5: For a receive pin, ser_rxd[k] equals the pin level when the pin's latch bit is 1 and its inverse when the latch bit is 0.
- R6: A clock pin drives both ser_cts[k] and ser_sclk_in[k]. Each one is the pin level, inverted when that pin's latch bit is 0.
- R7: rd_sel=3 reads the receive-source select in bit 0, with zeros above it. When the select is 1, ser_rxd[0] comes from alt_rxd instead of pin 1, and latch bit 1 still sets its polarity.
- R8: The function register has bits only for transmit and clock pins (mask 101101 for two channels). Writing 1 to a receive-pin bit has no effect, and that bit reads 0.
- R9: pad_out of a transmit pin or clock pin is ser_txd[k] or ser_sclk_out[k] when its function bit is 1, and its latch bit otherwise. pad_out of a receive pin is always its latch bit.
- R10: rd_sel=1 reads the direction register and rd_sel=2 reads the function register. Strobes raised together all take effect on the same edge.
- R11: The invert path is combinational from the latch. A latch write changes the polarity of a serial input only from the clock edge that stores it, never before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 6 | Write data for all registers |
| wr_latch | input | 1 | Latch write strobe |
| wr_dir | input | 1 | Direction write strobe |
| wr_func | input | 1 | Function write strobe |
| wr_alt | input | 1 | Receive-source select write strobe (bit 0 of wr_data) |
| rd_sel | input | 2 | Read selector: 0 port, 1 direction, 2 function, 3 source select |
| rd_data | output | 6 | Read data |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output levels |
| pad_oe | output | 6 | Pad output enables |
| alt_rxd | input | 1 | Alternate receive input for channel 0 |
| ser_txd | input | 2 | Transmit data from channels |
| ser_sclk_out | input | 2 | Serial clock outputs from channels |
| ser_rxd | output | 2 | Receive data to channels |
| ser_cts | output | 2 | Clear-to-send to channels |
| ser_sclk_in | output | 2 | Serial clock inputs to channels |

## Verification
A latch write and the inversion of a live serial input can fall in the same cycle, because the same latch bit serves both. The bench raises wr_latch while it holds the receive and clock pins steady. It checks the channel inputs after the strobe rises but before the edge, where they must still show the old polarity, and again after the edge, where they must show the new one. Raising all four write strobes at once is also judged, by reading each register back.

// File: rtl/sio_pin_pkg.sv
package sio_pin_pkg;
  localparam int PINS_PER_CH = 3;
  localparam int TX_OFS = 0;
  localparam int RX_OFS = 1;
  localparam int CK_OFS = 2;

  typedef enum logic [1:0] {
    RD_PORT = 2'd0,
    RD_DIR  = 2'd1,
    RD_FUNC = 2'd2,
    RD_ALT  = 2'd3
  } rd_sel_e;

  function automatic bit pin_has_func(input int idx);
    return (idx % PINS_PER_CH) != RX_OFS;
  endfunction
endpackage

// File: rtl/sio_port_regs.sv
module sio_port_regs
  import sio_pin_pkg::*;
#(
  parameter int NPIN = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] wr_data,
  input  logic            wr_latch,
  input  logic            wr_dir,
  input  logic            wr_func,
  input  logic            wr_alt,
  output logic [NPIN-1:0] latch_q,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] func_q,
  output logic            alt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '0;
      alt_q   <= 1'b0;
    end else begin
      if (wr_latch) latch_q <= wr_data;
      if (wr_dir)   dir_q   <= wr_data;
      if (wr_alt)   alt_q   <= wr_data[0];
    end
  end

  // function bits exist only on pins that can be driven by a channel
  for (genvar i = 0; i < NPIN; i++) begin : g_func
    if (pin_has_func(i)) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       func_q[i] <= 1'b0;
        else if (wr_func) func_q[i] <= wr_data[i];
      end
    end else begin : g_none
      assign func_q[i] = 1'b0;
    end
  end

  // R2: a strobed write lands at the next edge
  a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> latch_q == $past(wr_data));
  // R2: latch holds without a strobe
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_latch |=> $stable(latch_q));
  // R3: direction holds without a strobe
  a_r3_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  // R8: function register holds without a strobe
  a_r8_func_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_func |=> $stable(func_q));
endmodule

// File: rtl/sio_pin_slice.sv
module sio_pin_slice #(
  parameter bit HAS_FUNC = 1'b1
) (
  input  logic latch,
  input  logic dir,
  input  logic func,
  input  logic pin_in,
  input  logic ser_drive,
  output logic pin_out,
  output logic pin_oe,
  output logic rd_bit,
  output logic to_ser
);
  if (HAS_FUNC) begin : g_mux
    assign pin_out = func ? ser_drive : latch;
  end else begin : g_plain
    logic unused_in;
    assign unused_in = func ^ ser_drive;
    assign pin_out = latch;
  end

  assign pin_oe = dir;
  assign rd_bit = dir ? latch : pin_in;
  // latch 0 inverts the level handed to the channel
  assign to_ser = pin_in ^ ~latch;
endmodule

// File: rtl/sio_rx_route.sv
module sio_rx_route (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic alt_raw,
  input  logic alt_sel,
  input  logic polar,
  output logic rxd
);
  logic src;
  assign src = alt_sel ? alt_raw : pin_raw;
  assign rxd = src ^ ~polar;

  // R7: with the alternate source chosen, the pin must not reach the channel
  a_r7_alt_isolates_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel && $past(alt_sel) && $stable(alt_raw) && $stable(polar)) |-> $stable(rxd));
  // R5: with the pin chosen, the alternate input must not reach the channel
  a_r5_pin_isolates_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_sel && !$past(alt_sel) && $stable(pin_raw) && $stable(polar)) |-> $stable(rxd));
endmodule

// File: rtl/sio_pin_mux.sv
module sio_pin_mux
  import sio_pin_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NPIN = NCH * PINS_PER_CH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] wr_data,
  input  logic            wr_latch,
  input  logic            wr_dir,
  input  logic            wr_func,
  input  logic            wr_alt,
  input  logic [1:0]      rd_sel,
  output logic [NPIN-1:0] rd_data,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  input  logic            alt_rxd,
  input  logic [NCH-1:0]  ser_txd,
  input  logic [NCH-1:0]  ser_sclk_out,
  output logic [NCH-1:0]  ser_rxd,
  output logic [NCH-1:0]  ser_cts,
  output logic [NCH-1:0]  ser_sclk_in
);
  logic [NPIN-1:0] latch_q, dir_q, func_q, port_rd, pol_in, ser_drv;
  logic            alt_q;

  sio_port_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_latch(wr_latch), .wr_dir(wr_dir), .wr_func(wr_func), .wr_alt(wr_alt),
    .latch_q(latch_q), .dir_q(dir_q), .func_q(func_q), .alt_q(alt_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int B = c * PINS_PER_CH;
    assign ser_drv[B+TX_OFS] = ser_txd[c];
    assign ser_drv[B+RX_OFS] = 1'b0;
    assign ser_drv[B+CK_OFS] = ser_sclk_out[c];

    assign ser_cts[c]     = pol_in[B+CK_OFS];
    assign ser_sclk_in[c] = pol_in[B+CK_OFS];

    if (c == 0) begin : g_route
      sio_rx_route u_rx0 (
        .clk(clk), .rst_n(rst_n),
        .pin_raw(pad_in[B+RX_OFS]), .alt_raw(alt_rxd), .alt_sel(alt_q),
        .polar(latch_q[B+RX_OFS]), .rxd(ser_rxd[c])
      );
    end else begin : g_direct
      assign ser_rxd[c] = pol_in[B+RX_OFS];
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    sio_pin_slice #(.HAS_FUNC(pin_has_func(i))) u_slice (
      .latch(latch_q[i]), .dir(dir_q[i]), .func(func_q[i]),
      .pin_in(pad_in[i]), .ser_drive(ser_drv[i]),
      .pin_out(pad_out[i]), .pin_oe(pad_oe[i]),
      .rd_bit(port_rd[i]), .to_ser(pol_in[i])
    );
  end

  always_comb begin
    unique case (rd_sel_e'(rd_sel))
      RD_PORT: rd_data = port_rd;
      RD_DIR:  rd_data = dir_q;
      RD_FUNC: rd_data = func_q;
      RD_ALT:  rd_data = {{(NPIN-1){1'b0}}, alt_q};
      default: rd_data = '0;
    endcase
  end

  // R6: the clock pin feeds both channel inputs identically
  a_r6_cts_sclk_match: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cts == ser_sclk_in);
  // R11: polarity of channel 1 receive follows a latch write only after its edge
  a_r11_polarity_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (NCH > 1 && $stable(pad_in) && $stable(latch_q)) |-> $stable(ser_rxd[NCH-1]));
endmodule

// File: tb/sio_pin_mux_bench.sv
module sio_pin_mux_bench;
  localparam int NCH = 2;
  localparam int NP  = 6;
  localparam logic [5:0] FMASK = 6'b101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] wr_data = '0, pad_in = '0;
  logic wr_latch = 0, wr_dir = 0, wr_func = 0, wr_alt = 0, alt_rxd = 0;
  logic [1:0] rd_sel = 2'd0;
  logic [NCH-1:0] ser_txd = '0, ser_sclk_out = '0;
  logic [NP-1:0] rd_data, pad_out, pad_oe;
  logic [NCH-1:0] ser_rxd, ser_cts, ser_sclk_in;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sio_pin_mux u_sio_pin_mux (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_latch(wr_latch),
    .wr_dir(wr_dir), .wr_func(wr_func), .wr_alt(wr_alt), .rd_sel(rd_sel),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_rxd(alt_rxd), .ser_txd(ser_txd), .ser_sclk_out(ser_sclk_out),
    .ser_rxd(ser_rxd), .ser_cts(ser_cts), .ser_sclk_in(ser_sclk_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] strobes, input logic [5:0] d);
    @(negedge clk);
    wr_data = d;
    {wr_alt, wr_func, wr_dir, wr_latch} = strobes;
    @(negedge clk);
    {wr_alt, wr_func, wr_dir, wr_latch} = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [5:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic t_reset();
    logic [5:0] v;
    pad_in = 6'b011010; #1;
    rd(2'd1, v); check("R1 dir", {2'b0, v}, 8'h00);
    rd(2'd2, v); check("R1 func", {2'b0, v}, 8'h00);
    rd(2'd3, v); check("R1 alt", {2'b0, v}, 8'h00);
    check("R1 oe", {2'b0, pad_oe}, 8'h00);
    check("R1 pad_out latch ones", {2'b0, pad_out}, 8'h3F);
    rd(2'd0, v); check("R4 inputs read pins", {2'b0, v}, 8'h1A);
  endtask

  task automatic t_dir_port();
    logic [5:0] v;
    wr(4'b0001, 6'b110011);
    wr(4'b0010, 6'b101010);
    check("R3 oe follows dir", {2'b0, pad_oe}, 8'h2A);
    pad_in = 6'b000101; #1;
    rd(2'd0, v); check("R4 mixed read", {2'b0, v}, {2'b0, 6'b100111});
    rd(2'd1, v); check("R10 dir read", {2'b0, v}, 8'h2A);
    wr(4'b0010, 6'b000000);
  endtask

  task automatic t_rx_invert();
    wr(4'b0001, 6'b111111);
    pad_in = 6'b010010; #1;
    check("R5 rx pass", {6'b0, ser_rxd}, 8'h03);
    wr(4'b0001, 6'b101101);
    check("R5 rx invert", {6'b0, ser_rxd}, 8'h00);
    pad_in = 6'b000000; #1;
    check("R5 rx invert low", {6'b0, ser_rxd}, 8'h03);
  endtask

  task automatic t_clk_pins();
    wr(4'b0001, 6'b111111);
    pad_in = 6'b000100; #1;
    check("R6 cts pass", {6'b0, ser_cts}, 8'h01);
    check("R6 sclk pass", {6'b0, ser_sclk_in}, 8'h01);
    wr(4'b0001, 6'b011111);
    check("R6 cts inv ch1", {6'b0, ser_cts}, 8'h03);
    check("R6 sclk inv ch1", {6'b0, ser_sclk_in}, 8'h03);
  endtask

  task automatic t_alt();
    logic [5:0] v;
    wr(4'b0001, 6'b111111);
    wr(4'b1000, 6'b000001);
    rd(2'd3, v); check("R7 alt read", {2'b0, v}, 8'h01);
    pad_in = 6'b000010; alt_rxd = 1'b0; #1;
    check("R7 alt used not pin", {7'b0, ser_rxd[0]}, 8'h00);
    alt_rxd = 1'b1; #1;
    check("R7 alt high", {7'b0, ser_rxd[0]}, 8'h01);
    wr(4'b0001, 6'b111101);
    check("R7 alt inverted", {7'b0, ser_rxd[0]}, 8'h00);
    wr(4'b1000, 6'b000000);
    check("R7 back to pin inverted", {7'b0, ser_rxd[0]}, 8'h00);
    alt_rxd = 1'b0;
  endtask

  task automatic t_func();
    logic [5:0] v;
    wr(4'b0001, 6'b000000);
    wr(4'b0100, 6'b111111);
    rd(2'd2, v); check("R8 func mask", {2'b0, v}, {2'b0, FMASK});
    ser_txd = 2'b01; ser_sclk_out = 2'b10; #1;
    check("R9 serial drive", {2'b0, pad_out}, {2'b0, 6'b100001});
    wr(4'b0001, 6'b010010);
    check("R9 rx pins latch", {2'b0, pad_out}, {2'b0, 6'b110011});
    wr(4'b0100, 6'b000000);
    check("R9 plain latch", {2'b0, pad_out}, 8'h12);
    ser_txd = '0; ser_sclk_out = '0;
  endtask

  task automatic t_same_cycle();
    logic [5:0] v;
    wr(4'b0001, 6'b111111);
    pad_in = 6'b100110; #1;
    @(negedge clk);
    wr_data = 6'b000000; wr_latch = 1'b1; #1;
    check("R11 old polarity rx", {6'b0, ser_rxd}, 8'h01);
    check("R11 old polarity cts", {6'b0, ser_cts}, 8'h03);
    @(negedge clk); wr_latch = 1'b0;
    check("R11 new polarity rx", {6'b0, ser_rxd}, 8'h02);
    check("R11 new polarity cts", {6'b0, ser_cts}, 8'h00);
    @(negedge clk);
    wr_data = 6'b100101;
    {wr_alt, wr_func, wr_dir, wr_latch} = 4'b1111;
    @(negedge clk);
    {wr_alt, wr_func, wr_dir, wr_latch} = '0;
    rd(2'd1, v); check("R10 all dir", {2'b0, v}, 8'h25);
    rd(2'd2, v); check("R10 all func", {2'b0, v}, 8'h25);
    rd(2'd3, v); check("R10 all alt", {2'b0, v}, 8'h01);
    rd(2'd0, v); check("R10 all latch", {2'b0, v}, {2'b0, 6'b100111});
  endtask

  initial begin
    #1;
    check("R1 oe during reset", {2'b0, pad_oe}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir_port();
    t_rx_invert();
    t_clk_pins();
    t_alt();
    t_func();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule